// File: doc/BRIEF.md
# Three-Channel Block Transfer Engine

The block moves blocks of bytes between I/O ports and memory while the processor stays off the bus. It has three independent channels. Each channel holds a start address, a remaining byte count and a control word. The processor loads all three through a small register write port. Each port signals with a request line when it has data for memory or has room for data from memory.

When an eligible channel is requesting, the engine raises a hold request to the processor and waits for the hold acknowledge. The granted bus is then used for exactly one byte. In that single cycle the engine drives the channel address, acknowledges the port, and pulses one memory strobe together with the opposite I/O strobe. It then releases the hold request, so the processor can use the bus between bytes.

An end-of-block pulse marks the last byte of a channel's block. A periodic marker pulses whenever the remaining count falls onto a multiple of 128. A status read returns one end-of-block flag per channel and clears those flags.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: A write with `cfg_we_i` high loads channel `cfg_chan_i` (0..2). Register select 0 loads the address, 1 loads the count, and 2 loads the control word. In the control word, bit 0 is enable and bit 1 is direction. A write with channel select 3, or with register select 3, changes no channel.
- R2: `hold_req_o` rises in the cycle after an eligible channel requests. No `dack_o`, strobe or `io_drive_o` is active unless `hold_ack_i` is high.
- R3: Each grant carries one byte. The transfer cycle lasts one clock, and `hold_req_o` is low in the cycle after it.
- R4: In a transfer cycle, exactly one `dack_o` bit is high, `io_drive_o` is high, and `mem_addr_o` equals the channel's current address.
- R5: When direction is 1 (memory to port), the transfer cycle asserts `mem_rd_o` and `io_wr_o`. When direction is 0 (port to memory), it asserts `io_rd_o` and `mem_wr_o`. All strobes are active high, and the other two strobes stay low.
- R6: Each byte moved increments the channel address by 1 and decrements its count by 1.
- R7: `tc_o` is high only in the transfer cycle whose count before the byte is 1. That channel then clears its enable and ignores further requests until it is reprogrammed.
- R8: `mark_o` is high in a transfer cycle whose count after the byte is a multiple of 128, including zero.
- R9: When several eligible channels request at once, the lowest-numbered channel is served first.
- R10: `stat_rdata_o` bit i is set when channel i ends a block. A cycle with `stat_re_i` high clears all flags.
- R11: A channel whose enable bit is 0, or whose count is 0, never raises `hold_req_o`, whatever its request input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_chan_i | input | 2 | Channel select for the write |
| cfg_reg_i | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata_i | input | 16 | Write data |
| stat_re_i | input | 1 | Status read; clears the end-of-block flags |
| stat_rdata_o | output | 3 | End-of-block flag per channel |
| dreq_i | input | 3 | Transfer request per port |
| dack_o | output | 3 | Transfer acknowledge per port |
| hold_req_o | output | 1 | Bus hold request to the processor |
| hold_ack_i | input | 1 | Bus hold acknowledge from the processor |
| mem_addr_o | output | 16 | Memory address during a transfer, 0 otherwise |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| io_drive_o | output | 1 | Output enable for the shared I/O strobe lines |
| tc_o | output | 1 | End-of-block pulse |
| mark_o | output | 1 | Count-multiple-of-128 pulse |

## Verification
Several rules are checked by assertions on every cycle. No acknowledge or strobe appears without the bus grant. The acknowledge is one-hot. Memory and I/O strobes always come in opposite pairs. The hold request drops right after each byte. The end-of-block and marker pulses occur only inside a transfer cycle. Address stepping and count stepping are also checked cycle by cycle.

Other rules depend on history across many bytes, and only the bench's scenarios can show them. These include the order in which competing channels are served, the exact byte on which the end-of-block and marker pulses fall, and a finished, disabled or zero-count channel staying silent. They also include the rejected register selects and the read-to-clear status. The bench covers every block length from 1 to 8 on every channel in both directions, with varying grant delays, plus a 130-byte block for the marker.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    REG_ADDR  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_XFER = 2'd2
  } xfer_st_e;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_DIR = 1;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] count_o,
  output logic          en_o,
  output logic          dir_o,
  output logic          last_o
);
  logic wr_addr, wr_count, wr_ctrl;
  assign wr_addr  = wr_i && (reg_i == REG_ADDR);
  assign wr_count = wr_i && (reg_i == REG_COUNT);
  assign wr_ctrl  = wr_i && (reg_i == REG_CTRL);
  assign last_o   = (count_o == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      count_o <= '0;
      en_o    <= 1'b0;
      dir_o   <= 1'b0;
    end else begin
      if (wr_addr)      addr_o <= wdata_i[AW-1:0];
      else if (step_i)  addr_o <= addr_o + AW'(1);
      if (wr_count)     count_o <= wdata_i[CW-1:0];
      else if (step_i)  count_o <= count_o - CW'(1);
      if (wr_ctrl) begin
        en_o  <= wdata_i[CTRL_EN];
        dir_o <= wdata_i[CTRL_DIR];
      end else if (step_i && last_o) begin
        en_o <= 1'b0;
      end
    end
  end

  a_r6_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_addr) |=> (addr_o == $past(addr_o) + AW'(1)));
  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wr_count) |=> (count_o == $past(count_o) - CW'(1)));
  a_r7_disable_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !wr_ctrl) |=> !en_o);
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end
  assign any_o = |req_i;

  always_comb begin
    a_r9_gnt_onehot: assert ($onehot0(gnt_o));
    if (any_o) a_r9_gnt_nonzero: assert (gnt_o != '0);
  end
endmodule

// File: rtl/dma_stat.sv
module dma_stat #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_o <= '0;
    else if (clr_i) flags_o <= set_i;
    else            flags_o <= flags_o | set_i;
  end

  a_r10_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int SEL_W  = 2,
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int DW     = 16,
  parameter int MARK_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_chan_i,
  input  logic [1:0]       cfg_reg_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  input  logic             stat_re_i,
  output logic [NCH-1:0]   stat_rdata_o,
  input  logic [NCH-1:0]   dreq_i,
  output logic [NCH-1:0]   dack_o,
  output logic             hold_req_o,
  input  logic             hold_ack_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             io_rd_o,
  output logic             io_wr_o,
  output logic             io_drive_o,
  output logic             tc_o,
  output logic             mark_o
);
  xfer_st_e st_q;
  logic [NCH-1:0] cur_q, elig, gnt, step, chan_en, chan_dir, chan_last, tc_set;
  logic [AW-1:0] chan_addr [NCH];
  logic [CW-1:0] chan_cnt  [NCH];
  logic gnt_any, xfer;
  logic [AW-1:0] sel_addr;
  logic [CW-1:0] sel_cnt, cnt_after;
  logic sel_dir;

  assign xfer = (st_q == ST_XFER);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (cfg_we_i && (cfg_chan_i == SEL_W'(i))),
      .reg_i  (cfg_reg_i),
      .wdata_i(cfg_wdata_i),
      .step_i (step[i]),
      .addr_o (chan_addr[i]),
      .count_o(chan_cnt[i]),
      .en_o   (chan_en[i]),
      .dir_o  (chan_dir[i]),
      .last_o (chan_last[i])
    );
    assign elig[i]   = dreq_i[i] && chan_en[i] && (chan_cnt[i] != '0);
    assign step[i]   = xfer && cur_q[i];
    assign tc_set[i] = step[i] && chan_last[i];
  end

  dma_arb #(.N(NCH)) u_arb (
    .req_i(elig),
    .gnt_o(gnt),
    .any_o(gnt_any)
  );

  dma_stat #(.N(NCH)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tc_set),
    .clr_i  (stat_re_i),
    .flags_o(stat_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (gnt_any) begin
          cur_q <= gnt;
          st_q  <= ST_HOLD;
        end
        ST_HOLD: if (hold_ack_i) st_q <= ST_XFER;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sel_addr = '0;
    sel_cnt  = '0;
    sel_dir  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (cur_q[i]) begin
        sel_addr = sel_addr | chan_addr[i];
        sel_cnt  = sel_cnt  | chan_cnt[i];
        sel_dir  = sel_dir  | chan_dir[i];
      end
    end
  end

  assign cnt_after  = sel_cnt - CW'(1);
  assign hold_req_o = (st_q != ST_IDLE);
  assign dack_o     = xfer ? cur_q : '0;
  assign mem_addr_o = xfer ? sel_addr : '0;
  assign mem_rd_o   = xfer && sel_dir;
  assign io_wr_o    = xfer && sel_dir;
  assign mem_wr_o   = xfer && !sel_dir;
  assign io_rd_o    = xfer && !sel_dir;
  assign io_drive_o = xfer;
  assign tc_o       = xfer && (sel_cnt == CW'(1));
  assign mark_o     = xfer && (cnt_after[MARK_W-1:0] == '0);

  a_r2_grant_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dack_o || io_drive_o) |-> (hold_ack_i && hold_req_o));
  a_r3_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dack_o) |=> (!hold_req_o && dack_o == '0));
  a_r4_ack_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_drive_o |-> $onehot(dack_o));
  a_r5_mem_to_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (io_wr_o && !io_rd_o && !mem_wr_o));
  a_r5_port_to_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (io_rd_o && !io_wr_o && !mem_rd_o));
  a_r7_tc_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (|dack_o));
  a_r8_mark_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |-> (|dack_o));
  a_r10_flag_after_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> (stat_rdata_o & $past(dack_o)) != '0);
endmodule

// File: tb/dma_xfer_ctrl_test.sv
module dma_xfer_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_chan = '0, cfg_reg = '0;
  logic [15:0] cfg_wdata = '0;
  logic        stat_re = 1'b0;
  logic [2:0]  stat_rdata, dreq = '0, dack;
  logic        hold_req, hold_ack;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, io_drive, tc, mark;

  dma_xfer_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_chan_i(cfg_chan), .cfg_reg_i(cfg_reg), .cfg_wdata_i(cfg_wdata),
    .stat_re_i(stat_re), .stat_rdata_o(stat_rdata),
    .dreq_i(dreq), .dack_o(dack),
    .hold_req_o(hold_req), .hold_ack_i(hold_ack),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .io_rd_o(io_rd), .io_wr_o(io_wr), .io_drive_o(io_drive),
    .tc_o(tc), .mark_o(mark)
  );

  // processor model: grants the bus lat cycles after the hold request
  int lat = 0;
  int hcnt = 0;
  always_ff @(posedge clk) begin
    if (!hold_req) hcnt <= 0;
    else if (hcnt < lat) hcnt <= hcnt + 1;
  end
  assign hold_ack = hold_req && (hcnt >= lat);

  int total = 0, bad = 0, marks = 0;
  bit finished = 0;
  logic [15:0] m_addr [3];
  logic [15:0] m_cnt  [3];
  bit m_en [3];
  bit m_dir [3];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_winner();
    for (int i = 0; i < 3; i++)
      if (dreq[i] && m_en[i] && m_cnt[i] != 0) return i;
    return -1;
  endfunction

  // transfer monitor: checks every observed byte against the model
  bit prev_x = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_x) chk(!hold_req, "R3 hold released after byte", hold_req, 0);
      if (!hold_ack) chk(dack == 0 && !io_drive && !mem_rd && !mem_wr && !io_rd && !io_wr,
                         "R2 no bus activity without grant", dack, 0);
      prev_x = (dack != 0);
      if (dack != 0) begin
        int w, c;
        w = exp_winner();
        c = (dack == 3'b001) ? 0 : (dack == 3'b010) ? 1 : (dack == 3'b100) ? 2 : -1;
        chk($countones(dack) == 1 && io_drive, "R4 one ack and drive", dack, 1);
        chk(c == w, "R9 priority winner", c, w);
        if (c >= 0) begin
          chk(mem_addr == m_addr[c], "R4 R6 address", mem_addr, m_addr[c]);
          chk(mem_rd == m_dir[c] && io_wr == m_dir[c] && mem_wr == !m_dir[c] && io_rd == !m_dir[c],
              "R5 strobes", {mem_rd, mem_wr, io_rd, io_wr}, m_dir[c] ? 9 : 6);
          chk(tc == (m_cnt[c] == 1), "R7 terminal count", tc, m_cnt[c] == 1);
          chk(mark == (((m_cnt[c] - 16'd1) % 128) == 0), "R8 mark", mark,
              ((m_cnt[c] - 16'd1) % 128) == 0);
          if (mark) marks++;
          m_addr[c] = m_addr[c] + 1;
          m_cnt[c]  = m_cnt[c] - 1;
          if (m_cnt[c] == 0) m_en[c] = 0;
        end
      end
    end
  end

  task automatic wr(input int ch, input int r, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_chan = 2'(ch); cfg_reg = 2'(r); cfg_wdata = 16'(d);
    if (ch < 3) begin
      if (r == 0) m_addr[ch] = 16'(d);
      if (r == 1) m_cnt[ch] = 16'(d);
      if (r == 2) begin m_en[ch] = d[0]; m_dir[ch] = d[1]; end
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic prog(input int ch, input int a, input int n, input int dir);
    wr(ch, 0, a); wr(ch, 1, n); wr(ch, 2, 1 | (dir << 1));
  endtask

  task automatic wait_done(input int ch);
    int t = 0;
    while (m_en[ch] && t < 5000) begin @(negedge clk); t++; end
    chk(!m_en[ch], "R6 block completes", t, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic quiet(input int cycles, input string tag);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (hold_req) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic read_stat(input int exp);
    @(negedge clk);
    chk(stat_rdata == 3'(exp), "R10 status flags", stat_rdata, exp);
    stat_re = 1;
    @(negedge clk);
    stat_re = 0;
    chk(stat_rdata == 0, "R10 flags cleared by read", stat_rdata, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin m_addr[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_dir[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!hold_req && dack == 0 && mem_addr == 0 && !tc && !mark && stat_rdata == 0,
        "R1 reset state", {hold_req, dack}, 0);

    // R2 / R7: one block, then the finished channel stays silent
    lat = 2;
    prog(0, 'h1000, 5, 1);
    dreq = 3'b001;
    @(negedge clk);
    chk(hold_req, "R2 hold request raised", hold_req, 1);
    wait_done(0);
    quiet(20, "R7 finished channel ignores request");
    dreq = 0;
    read_stat(1);

    // R9: three channels compete
    lat = 1;
    prog(0, 'h2000, 3, 0); prog(1, 'h3000, 3, 1); prog(2, 'h4000, 3, 0);
    dreq = 3'b111;
    wait_done(0); wait_done(1); wait_done(2);
    dreq = 0;
    read_stat(7);

    // near-exhaustive sweep: every channel, both directions, lengths 1..8
    for (int dir = 0; dir < 2; dir++)
      for (int ch = 0; ch < 3; ch++)
        for (int n = 1; n <= 8; n++) begin
          lat = (n + ch) % 4;
          prog(ch, 'h100 * (ch + 1) + 16 * n + dir, n, dir);
          dreq = 3'(1 << ch);
          wait_done(ch);
          dreq = 0;
          read_stat(1 << ch);
        end

    // R8: 130-byte block marks at 128 and at 0
    lat = 0;
    marks = 0;
    prog(1, 'hFFF0, 130, 1);
    dreq = 3'b010;
    wait_done(1);
    dreq = 0;
    chk(marks == 2, "R8 mark count over 130 bytes", marks, 2);
    read_stat(2);

    // R11: disabled channel and zero-count channel
    wr(2, 0, 'h50); wr(2, 1, 4); wr(2, 2, 0);
    dreq = 3'b100;
    quiet(20, "R11 disabled channel silent");
    wr(2, 1, 0); wr(2, 2, 1);
    quiet(20, "R11 zero count silent");
    dreq = 0;
    wr(2, 2, 0);

    // R1: writes to select 3 leave the channels unchanged
    wr(0, 0, 'h40); wr(0, 1, 2);
    wr(3, 0, 'hBEEF); wr(3, 1, 9); wr(3, 2, 3);
    wr(0, 3, 'h77);
    quiet(10, "R1 select 3 does not enable");
    wr(0, 2, 1);
    dreq = 3'b001;
    wait_done(0);
    dreq = 0;
    chk(m_addr[0] == 'h42, "R1 channel 0 kept its address", m_addr[0], 'h42);
    read_stat(1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R3 watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule